// File: doc/BRIEF.md
# SPI Host Command Segment Sequencer

This block turns command words into SPI transfer segments. A register-style write port delivers command words and chip-select selections. Each command word is checked as it is written. A legal command goes into a small descriptor queue; an illegal one raises a sticky error and is dropped. While both the block enable and the output enable are high, the sequencer takes descriptors from the head of the queue one at a time and runs each as a segment against the selected target.

The link is modelled at byte level: each step of a segment is one byte exchange with the target. In a transmit direction, each step takes a byte from an external transmit queue, or sends zero when that queue is empty. In a receive direction, each step pushes the target's reply byte to an external receive queue. A hold flag in the descriptor keeps the chip select asserted after the segment ends, so the next segment continues the same frame.

Top module: `spi_seg_seq`

## Requirements
- R1: A command word is 14 bits: length in [8:0], hold flag in [9], speed in [11:10], direction in [13:12]. A segment with a non-dummy direction exchanges length+1 bytes, one byte per clock while `xfer_o` is high.
- R2: Direction codes are 0 dummy, 1 receive only, 2 transmit only, 3 both. A dummy segment makes no exchange. A transmit direction pops one byte per exchange and drives it on `sdo_byte_o`. A receive direction pushes `sdi_byte_i` on `rx_data_o` once per exchange. Receive only drives zero on `sdo_byte_o` and pops nothing.
- R3: In a transmit direction, an exchange made while `tx_empty_i` is high sends 0x00 and does not pop.
- R4: Speed code 3 (reserved), or direction 3 with any speed other than 0, rejects the command. A rejected command sets `err_cmd_inval_o` one clock after the write and is not queued. Speeds 1 and 2 are accepted for the other directions.
- R5: The queue holds 4 descriptors and `ready_o` is low while it is full. A legal command written while the queue is full is dropped and sets `err_busy_o`.
- R6: Descriptors start only while `blk_en_i` and `out_en_i` are both high. Raising both starts draining the commands already queued, in order.
- R7: At the end of a segment whose hold flag is clear, every `cs_n_o` line is high on the next clock. With the hold flag set, the selected line stays low until a later segment without the hold flag ends.
- R8: A chip-select write with a value of at least NUM_CS sets `err_csid_o` and keeps the previous selection. At most one `cs_n_o` line is low at any time, and it is the selected one.
- R9: `active_o` is high while a segment runs. Once the queue has drained, `ready_o` is 1 and `active_o` is 0.
- R10: A command write on the same clock as the engine takes the queue head is accepted, and both segments run.
- R11: After reset, `ready_o` is 1, `active_o` is 0, all `cs_n_o` lines are high and all error flags are 0. Each error flag is cleared by its bit of `err_clr_i`: bit 0 command-invalid, bit 1 busy, bit 2 chip-select ID. On the same clock, a new error wins over the clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| blk_en_i | input | 1 | Block enable |
| out_en_i | input | 1 | Output enable |
| cmd_we_i | input | 1 | Command word write strobe |
| cmd_wdata_i | input | 14 | Command word |
| csid_we_i | input | 1 | Chip-select selection write strobe |
| csid_wdata_i | input | 32 | Requested chip-select index |
| err_clr_i | input | 3 | Per-flag error clear |
| tx_empty_i | input | 1 | Transmit queue is empty |
| tx_data_i | input | 8 | Head byte of the transmit queue |
| tx_pop_o | output | 1 | Consume the transmit head byte |
| xfer_o | output | 1 | A byte exchange happens this clock |
| sdo_byte_o | output | 8 | Byte sent to the target |
| sdi_byte_i | input | 8 | Byte returned by the target |
| rx_push_o | output | 1 | Push a received byte |
| rx_data_o | output | 8 | Received byte |
| cs_n_o | output | NUM_CS | Chip selects, active low |
| ready_o | output | 1 | The command queue can accept a descriptor |
| active_o | output | 1 | A segment is running |
| err_cmd_inval_o | output | 1 | Sticky: an illegal command was written |
| err_busy_o | output | 1 | Sticky: a command was dropped because the queue was full |
| err_csid_o | output | 1 | Sticky: an out-of-range chip-select index was written |

## Verification
A command enqueue and a descriptor dequeue can fall on the same clock edge. If the queue occupancy is updated wrongly on that edge, a segment is lost or repeated. The bench provokes this by holding the output enable low with one descriptor queued. It then raises the enable and writes a second command in the same cycle, so the head is popped while the new descriptor is pushed. Both segments are judged at the ports: the scoreboard must see exactly the expected byte stream for each segment, with nothing left over and nothing extra, followed by ready high and active low.

// File: rtl/spi_seg_pkg.sv
package spi_seg_pkg;
  localparam int unsigned LEN_W = 9;
  localparam int unsigned CMD_W = 14;

  typedef enum logic [1:0] {
    DIR_NONE = 2'd0,
    DIR_RX   = 2'd1,
    DIR_TX   = 2'd2,
    DIR_TXRX = 2'd3
  } seg_dir_e;

  typedef enum logic [1:0] {
    SPD_STD  = 2'd0,
    SPD_DUAL = 2'd1,
    SPD_QUAD = 2'd2,
    SPD_RSVD = 2'd3
  } seg_spd_e;

  typedef struct packed {
    logic [LEN_W-1:0] len;
    logic             hold;
    seg_dir_e         dir;
  } seg_desc_t;
endpackage

// File: rtl/spi_seg_cmd_check.sv
module spi_seg_cmd_check
  import spi_seg_pkg::*;
(
  input  logic [CMD_W-1:0] cmd_i,
  output seg_desc_t        desc_o,
  output logic             legal_o
);
  seg_spd_e spd;

  assign spd         = seg_spd_e'(cmd_i[11:10]);
  assign desc_o.len  = cmd_i[LEN_W-1:0];
  assign desc_o.hold = cmd_i[9];
  assign desc_o.dir  = seg_dir_e'(cmd_i[13:12]);

  // multi-lane speeds cannot carry full-duplex traffic
  assign legal_o = (spd != SPD_RSVD) && !((desc_o.dir == DIR_TXRX) && (spd != SPD_STD));
endmodule

// File: rtl/spi_seg_fifo.sv
module spi_seg_fifo #(
  parameter int unsigned DEPTH = 4,
  parameter int unsigned W     = 12,
  localparam int unsigned AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         push_i,
  input  logic [W-1:0] wdata_i,
  input  logic         pop_i,
  output logic [W-1:0] rdata_o,
  output logic         full_o,
  output logic         empty_o
);
  logic [W-1:0]  mem_q [DEPTH];
  logic [AW-1:0] wptr_q, rptr_q;
  logic [CW-1:0] cnt_q;

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full_o  = (cnt_q == CW'(DEPTH));
  assign empty_o = (cnt_q == '0);
  assign rdata_o = mem_q[rptr_q];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wptr_q <= '0;
      rptr_q <= '0;
      cnt_q  <= '0;
    end else begin
      if (push_i) wptr_q <= nxt(wptr_q);
      if (pop_i)  rptr_q <= nxt(rptr_q);
      unique case ({push_i, pop_i})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  always_ff @(posedge clk_i) begin
    if (push_i) mem_q[wptr_q] <= wdata_i;
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i |-> !full_o); // R5
  AST_NO_UNDERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i |-> !empty_o); // R6
endmodule

// File: rtl/spi_seg_engine.sv
module spi_seg_engine
  import spi_seg_pkg::*;
#(
  parameter int unsigned NUM_CS = 4,
  localparam int unsigned CSW   = (NUM_CS > 1) ? $clog2(NUM_CS) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              run_i,
  input  logic              avail_i,
  input  seg_desc_t         desc_i,
  output logic              pop_o,
  input  logic [CSW-1:0]    csid_i,
  input  logic              tx_empty_i,
  input  logic [7:0]        tx_data_i,
  output logic              tx_pop_o,
  output logic              xfer_o,
  output logic [7:0]        sdo_byte_o,
  input  logic [7:0]        sdi_byte_i,
  output logic              rx_push_o,
  output logic [7:0]        rx_data_o,
  output logic [NUM_CS-1:0] cs_n_o,
  output logic              busy_o
);
  logic             busy_q, hold_q, held_q;
  logic [LEN_W-1:0] cnt_q;
  seg_dir_e         dir_q;
  logic             dir_tx, dir_rx, cs_on;

  assign dir_tx = (dir_q == DIR_TX) || (dir_q == DIR_TXRX);
  assign dir_rx = (dir_q == DIR_RX) || (dir_q == DIR_TXRX);

  assign pop_o  = !busy_q && run_i && avail_i;
  assign busy_o = busy_q;
  assign xfer_o = busy_q && (dir_q != DIR_NONE);

  assign tx_pop_o   = xfer_o && dir_tx && !tx_empty_i;
  assign sdo_byte_o = (dir_tx && !tx_empty_i) ? tx_data_i : 8'h00;
  assign rx_push_o  = xfer_o && dir_rx;
  assign rx_data_o  = sdi_byte_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      hold_q <= 1'b0;
      held_q <= 1'b0;
      cnt_q  <= '0;
      dir_q  <= DIR_NONE;
    end else if (pop_o) begin
      busy_q <= 1'b1;
      cnt_q  <= desc_i.len;
      dir_q  <= desc_i.dir;
      hold_q <= desc_i.hold;
    end else if (busy_q) begin
      if (dir_q == DIR_NONE) begin
        busy_q <= 1'b0;
      end else if (cnt_q == '0) begin
        busy_q <= 1'b0;
        held_q <= hold_q;
      end else begin
        cnt_q <= cnt_q - 1'b1;
      end
    end
  end

  assign cs_on = xfer_o || held_q;

  for (genvar g = 0; g < NUM_CS; g++) begin : g_cs
    assign cs_n_o[g] = !(cs_on && (csid_i == CSW'(g)));
  end

  AST_CS_RELEASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (xfer_o && (cnt_q == '0) && !hold_q) |=> (&cs_n_o)); // R7
  AST_CS_KEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (xfer_o && (cnt_q == '0) && hold_q) |=> !(&cs_n_o)); // R7
  AST_ACTIVE_XFER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_pop_o || rx_push_o) |-> busy_o); // R9
endmodule

// File: rtl/spi_seg_seq.sv
module spi_seg_seq
  import spi_seg_pkg::*;
#(
  parameter int unsigned NUM_CS    = 4,
  parameter int unsigned CMD_DEPTH = 4,
  localparam int unsigned CSW      = (NUM_CS > 1) ? $clog2(NUM_CS) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              blk_en_i,
  input  logic              out_en_i,
  input  logic              cmd_we_i,
  input  logic [13:0]       cmd_wdata_i,
  input  logic              csid_we_i,
  input  logic [31:0]       csid_wdata_i,
  input  logic [2:0]        err_clr_i,
  input  logic              tx_empty_i,
  input  logic [7:0]        tx_data_i,
  output logic              tx_pop_o,
  output logic              xfer_o,
  output logic [7:0]        sdo_byte_o,
  input  logic [7:0]        sdi_byte_i,
  output logic              rx_push_o,
  output logic [7:0]        rx_data_o,
  output logic [NUM_CS-1:0] cs_n_o,
  output logic              ready_o,
  output logic              active_o,
  output logic              err_cmd_inval_o,
  output logic              err_busy_o,
  output logic              err_csid_o
);
  localparam int unsigned DW = $bits(seg_desc_t);

  seg_desc_t      new_desc, head_desc;
  logic           cmd_ok, q_push, q_pop, q_full, q_empty, run_en, csid_bad;
  logic [CSW-1:0] csid_q;
  logic [DW-1:0]  head_raw;
  logic           inval_q, busy_err_q, csid_err_q;

  spi_seg_cmd_check u_check (
    .cmd_i   (cmd_wdata_i),
    .desc_o  (new_desc),
    .legal_o (cmd_ok)
  );

  assign q_push = cmd_we_i && cmd_ok && !q_full;

  spi_seg_fifo #(.DEPTH(CMD_DEPTH), .W(DW)) u_queue (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .push_i  (q_push),
    .wdata_i (new_desc),
    .pop_i   (q_pop),
    .rdata_o (head_raw),
    .full_o  (q_full),
    .empty_o (q_empty)
  );

  assign head_desc = head_raw;
  assign run_en    = blk_en_i && out_en_i;

  spi_seg_engine #(.NUM_CS(NUM_CS)) u_engine (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .run_i      (run_en),
    .avail_i    (!q_empty),
    .desc_i     (head_desc),
    .pop_o      (q_pop),
    .csid_i     (csid_q),
    .tx_empty_i (tx_empty_i),
    .tx_data_i  (tx_data_i),
    .tx_pop_o   (tx_pop_o),
    .xfer_o     (xfer_o),
    .sdo_byte_o (sdo_byte_o),
    .sdi_byte_i (sdi_byte_i),
    .rx_push_o  (rx_push_o),
    .rx_data_o  (rx_data_o),
    .cs_n_o     (cs_n_o),
    .busy_o     (active_o)
  );

  assign csid_bad = csid_wdata_i >= 32'(NUM_CS);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      csid_q <= '0;
    end else if (csid_we_i && !csid_bad) begin
      csid_q <= csid_wdata_i[CSW-1:0];
    end
  end

  // set has priority over clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      inval_q    <= 1'b0;
      busy_err_q <= 1'b0;
      csid_err_q <= 1'b0;
    end else begin
      inval_q    <= (inval_q    && !err_clr_i[0]) || (cmd_we_i && !cmd_ok);
      busy_err_q <= (busy_err_q && !err_clr_i[1]) || (cmd_we_i && cmd_ok && q_full);
      csid_err_q <= (csid_err_q && !err_clr_i[2]) || (csid_we_i && csid_bad);
    end
  end

  assign ready_o         = !q_full;
  assign err_cmd_inval_o = inval_q;
  assign err_busy_o      = busy_err_q;
  assign err_csid_o      = csid_err_q;

  AST_REJECT_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_we_i && !cmd_ok) |=> err_cmd_inval_o); // R4
  AST_REJECT_NOQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_we_i && !cmd_ok) |-> !q_push); // R4
  AST_FULL_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_we_i && cmd_ok && !ready_o) |=> err_busy_o); // R5
  AST_RUN_GATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    q_pop |-> (blk_en_i && out_en_i)); // R6
  AST_CSID_KEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (csid_we_i && csid_bad) |=> $stable(csid_q)); // R8
  AST_ONE_CS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(~cs_n_o)); // R8
endmodule

// File: tb/spi_seg_seq_tb_top.sv
module spi_seg_seq_tb_top;
  localparam int NCS = 4;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic blk_en_i = 1'b0, out_en_i = 1'b0;
  logic cmd_we_i = 1'b0;
  logic [13:0] cmd_wdata_i = '0;
  logic csid_we_i = 1'b0;
  logic [31:0] csid_wdata_i = '0;
  logic [2:0] err_clr_i = '0;
  logic tx_empty_i, tx_pop_o, xfer_o, rx_push_o;
  logic [7:0] tx_data_i, sdo_byte_o, sdi_byte_i, rx_data_o;
  logic [NCS-1:0] cs_n_o;
  logic ready_o, active_o, err_cmd_inval_o, err_busy_o, err_csid_o;

  always #2.5 clk_i = ~clk_i;

  logic [7:0] txq [64];
  int tx_wr = 0, tx_rd = 0, mrd = 0;
  int cur_cs = 0;
  int vectors = 0, fails = 0;
  bit done = 0;
  logic [11:0] exp_tx [$];
  logic [7:0]  exp_rx [$];

  assign tx_empty_i = (tx_rd == tx_wr);
  assign tx_data_i  = txq[tx_rd[5:0]];
  assign sdi_byte_i = sdo_byte_o ^ 8'h5A;

  always @(posedge clk_i) if (tx_pop_o) tx_rd <= tx_rd + 1;

  spi_seg_seq #(.NUM_CS(NCS)) dut_i (
    .clk_i, .rst_ni, .blk_en_i, .out_en_i, .cmd_we_i, .cmd_wdata_i,
    .csid_we_i, .csid_wdata_i, .err_clr_i, .tx_empty_i, .tx_data_i,
    .tx_pop_o, .xfer_o, .sdo_byte_o, .sdi_byte_i, .rx_push_o, .rx_data_o,
    .cs_n_o, .ready_o, .active_o, .err_cmd_inval_o, .err_busy_o, .err_csid_o
  );

  task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", rq, act, exp);
    end
  endtask

  // monitor: compare every exchange and every receive push
  always @(negedge clk_i) begin
    if (rst_ni && xfer_o) begin
      if (exp_tx.size() == 0) chk("R2 unexpected exchange", {cs_n_o, sdo_byte_o}, 32'hFFFF_FFFF);
      else begin
        logic [11:0] e;
        e = exp_tx.pop_front();
        chk("R1/R3/R8 exchange", {20'h0, cs_n_o, sdo_byte_o}, {20'h0, e});
      end
    end
    if (rst_ni && rx_push_o) begin
      if (exp_rx.size() == 0) chk("R2 unexpected rx push", {24'h0, rx_data_o}, 32'hFFFF_FFFF);
      else begin
        logic [7:0] r;
        r = exp_rx.pop_front();
        chk("R2 rx byte", {24'h0, rx_data_o}, {24'h0, r});
      end
    end
  end

  task automatic load_tx(input logic [7:0] b);
    txq[tx_wr[5:0]] = b;
    tx_wr++;
  endtask

  // driver: predicts the segment, then writes the command word
  task automatic send_cmd(input int len, input bit hold, input int spd, input int dir, input bit accept);
    if (accept && dir != 0) begin
      for (int i = 0; i <= len; i++) begin
        logic [7:0] b;
        b = 8'h00;
        if (dir >= 2 && mrd < tx_wr) begin
          b = txq[mrd[5:0]];
          mrd++;
        end
        exp_tx.push_back({~(4'b1 << cur_cs), b});
        if (dir == 1 || dir == 3) exp_rx.push_back(b ^ 8'h5A);
      end
    end
    @(negedge clk_i);
    cmd_wdata_i = {dir[1:0], spd[1:0], hold, len[8:0]};
    cmd_we_i = 1'b1;
    @(negedge clk_i);
    cmd_we_i = 1'b0;
  endtask

  task automatic set_cs(input int id);
    @(negedge clk_i);
    csid_wdata_i = id;
    csid_we_i = 1'b1;
    @(negedge clk_i);
    csid_we_i = 1'b0;
    if (id < NCS) cur_cs = id;
  endtask

  task automatic clr(input logic [2:0] m);
    @(negedge clk_i);
    err_clr_i = m;
    @(negedge clk_i);
    err_clr_i = '0;
  endtask

  task automatic quiet(input string rq);
    repeat (30) @(negedge clk_i);
    chk({rq, " tx stream drained"}, exp_tx.size(), 0);
    chk({rq, " rx stream drained"}, exp_rx.size(), 0);
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      fails++;
      $display("FAIL R9 watchdog: actual hung expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    // R11 reset state
    chk("R11 ready", ready_o, 1);
    chk("R11 active", active_o, 0);
    chk("R11 cs", cs_n_o, 4'hF);
    chk("R11 errors", {err_cmd_inval_o, err_busy_o, err_csid_o}, 0);

    blk_en_i = 1'b1; out_en_i = 1'b1;
    // R1/R2 full duplex, 3 bytes
    set_cs(1);
    load_tx(8'h11); load_tx(8'h22); load_tx(8'h33);
    send_cmd(2, 0, 0, 3, 1);
    repeat (3) @(negedge clk_i);
    chk("R9 active mid segment", active_o, 1);
    quiet("R1");
    chk("R7 released", cs_n_o, 4'hF);
    chk("R9 ready after drain", ready_o, 1);
    chk("R9 idle after drain", active_o, 0);

    // R3 transmit only with one byte queued for two exchanges
    load_tx(8'hC3);
    send_cmd(1, 0, 0, 2, 1);
    quiet("R3");

    // R2 receive only, transmit queue untouched
    load_tx(8'h77);
    send_cmd(3, 0, 0, 1, 1);
    quiet("R2");
    chk("R2 rx-only pops nothing", tx_wr - tx_rd, 1);
    send_cmd(0, 0, 2, 2, 1); // R4 quad speed legal for transmit only
    quiet("R4 quad");

    // R4 rejections
    send_cmd(4, 0, 3, 2, 0);
    @(negedge clk_i);
    chk("R4 reserved speed flag", err_cmd_inval_o, 1);
    clr(3'b001);
    chk("R11 clear inval", err_cmd_inval_o, 0);
    send_cmd(4, 0, 1, 3, 0);
    @(negedge clk_i);
    chk("R4 dual full-duplex flag", err_cmd_inval_o, 1);
    quiet("R4 nothing queued");
    chk("R4 no pop", active_o, 0);

    // R2 dummy segment
    send_cmd(5, 0, 0, 0, 1);
    quiet("R2 dummy");
    chk("R2 dummy cs", cs_n_o, 4'hF);

    // R5/R6 gating and full queue
    out_en_i = 1'b0;
    for (int k = 0; k < 4; k++) load_tx(8'hA0 + k[7:0]);
    for (int k = 0; k < 4; k++) send_cmd(0, 0, 0, 2, 1);
    chk("R5 ready low when full", ready_o, 0);
    send_cmd(0, 0, 0, 2, 0);
    @(negedge clk_i);
    chk("R5 busy flag", err_busy_o, 1);
    repeat (10) @(negedge clk_i);
    chk("R6 nothing runs while gated", exp_tx.size(), 4);
    @(negedge clk_i);
    out_en_i = 1'b1;
    quiet("R6");
    chk("R5 ready after drain", ready_o, 1);
    clr(3'b010);
    chk("R11 clear busy", err_busy_o, 0);

    // R10 push on the same edge as pop
    out_en_i = 1'b0;
    load_tx(8'h5C); load_tx(8'hE1); load_tx(8'hE2);
    send_cmd(0, 0, 0, 2, 1);
    begin
      logic [7:0] b;
      for (int i = 0; i < 2; i++) begin
        b = txq[mrd[5:0]]; mrd++;
        exp_tx.push_back({~(4'b1 << cur_cs), b});
      end
    end
    @(negedge clk_i);
    out_en_i = 1'b1;
    cmd_wdata_i = {2'd2, 2'd0, 1'b0, 9'd1};
    cmd_we_i = 1'b1;
    @(negedge clk_i);
    cmd_we_i = 1'b0;
    quiet("R10");
    chk("R10 ready", ready_o, 1);

    // R7 hold chip select across segments
    set_cs(2);
    load_tx(8'h01); load_tx(8'h02);
    send_cmd(0, 1, 0, 2, 1);
    quiet("R7 hold");
    chk("R7 held low", cs_n_o, 4'hB);
    send_cmd(0, 0, 0, 2, 1);
    quiet("R7 end");
    chk("R7 released after", cs_n_o, 4'hF);

    // R8 out-of-range selection
    set_cs(4);
    chk("R8 csid flag", err_csid_o, 1);
    clr(3'b100);
    chk("R11 clear csid", err_csid_o, 0);
    set_cs(9);
    chk("R8 csid flag again", err_csid_o, 1);
    load_tx(8'h9D);
    send_cmd(0, 0, 0, 3, 1); // must still use line 2
    quiet("R8");

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule